// File: doc/BRIEF.md
# Input Event Ring Buffer Writer

This block turns keyboard and mouse activity into fixed four-word records and stores them in a circular buffer in word-addressed memory. A key event is a strobe carrying a 7-bit key code and a release flag. Mouse activity is reported as single-cycle unit-step pulses on four direction lines, together with the levels of three buttons. Each state change produces one record. The first word of a record packs the step bits, the button levels, the key code, the release flag and a flag that tells whether the record comes from the keyboard. The other three words are written as zero.

Software describes the ring with a base address, which is the first word, and a limit address, which is one past the last word. The block owns the write (in) pointer. Software owns the read (out) pointer, and the block exposes it as a loadable register. The ring is empty when the two pointers are equal. A record is refused when storing it would make the pointers equal. Refused records and records lost to the small internal queue set a sticky overflow flag. After the fourth word of a record has been stored, the in pointer advances and the interrupt lines selected by the sync mask pulse for one cycle.

Top module: `evq_ring_writer`

## Requirements
- R1: A stored record takes four consecutive cycles with `mem_we` high, at addresses in_ptr+0, +1, +2 and +3 in that order, all inside [ring_base, ring_end).
- R2: Word 0 of a record has this layout: bit 15 step X up, bit 14 step X down, bit 13 step Y up, bit 12 step Y down, bit 11 left button, bit 10 middle button, bit 9 right button, bits 8:2 key code, bit 1 release flag, bit 0 keyboard flag.
- R3: A cycle with `key_stb` high makes a keyboard record: step bits 0, button bits equal to `mouse_btn` in that cycle, code and release flag from the key inputs, keyboard flag 1.
- R4: A cycle with any `mouse_step` bit set, or with `mouse_btn` different from its value in the previous cycle, makes a mouse record: step bits from `mouse_step` ({X up, X down, Y up, Y down}), button bits from `mouse_btn` ({left, middle, right}), code 0, release 0, keyboard flag 0. Words 1 to 3 of every record are 0.
- R5: In the cycle after word 3 is stored, `in_ptr` holds its advanced value and `irq` equals `sync_mask` for exactly that one cycle. `irq` is 0 in every other cycle.
- R6: The in pointer advances by 4, except that when in_ptr+4 equals `ring_end` it becomes `ring_base`.
- R7: When the advanced in pointer would equal `out_ptr`, the record is discarded without any memory write, `in_ptr` stays unchanged, and `overflow` becomes 1 and stays 1 until reset.
- R8: When a key record and a mouse record arise in the same cycle, the key record is stored first. At most FIFO_DEPTH records wait. A record that finds no free queue slot, counted before that cycle's removal, is lost and sets `overflow`.
- R9: When `out_wr` is high, `out_ptr` takes `out_wdata` at the next clock edge.
- R10: After reset, `in_ptr` and `out_ptr` equal RING_RESET_ADDR (0x0100 by default), and `irq`, `overflow` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_stb | input | 1 | Key event strobe, one cycle per event |
| key_code | input | 7 | Key code of the event |
| key_up | input | 1 | 1 = key released, 0 = key pressed |
| mouse_btn | input | 3 | Button levels {left, middle, right} |
| mouse_step | input | 4 | Unit step pulses {X up, X down, Y up, Y down} |
| ring_base | input | AW | First word of the ring |
| ring_end | input | AW | One past the last word of the ring |
| out_wr | input | 1 | Load the out pointer |
| out_wdata | input | AW | New out pointer value |
| sync_mask | input | NIRQ | Interrupt lines to pulse per stored record |
| mem_we | output | 1 | Memory word write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| in_ptr | output | AW | Current in pointer |
| out_ptr | output | AW | Current out pointer |
| irq | output | NIRQ | Interrupt pulse lines |
| overflow | output | 1 | Sticky lost-record flag |

## Verification
The assertions assume that `ring_base` and `ring_end` are quadword aligned, that the limit lies above the base, and that both stay constant while records are in flight. They also assume that `out_wdata` is always a record boundary inside the ring. The stimulus changes the ring only through reset and loads the out pointer only with record addresses inside the ring. Inside those limits it drives single events, combined mouse and key events, bursts that exhaust the queue, a ring filled up to the full condition, and a wrap past the limit address.

// File: rtl/evq_pkg.sv
package evq_pkg;
   localparam int WORD_W      = 16;
   localparam int ENTRY_WORDS = 4;
   localparam int CODE_W      = 7;

   typedef struct packed {
      logic [3:0]        step;   // {x_up, x_dn, y_up, y_dn}
      logic [2:0]        btn;    // {left, middle, right}
      logic [CODE_W-1:0] code;
      logic              rel;
      logic              kbd;
   } evq_word_t;
endpackage

// File: rtl/evq_encoder.sv
module evq_encoder
   import evq_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              key_stb,
   input  logic [CODE_W-1:0] key_code,
   input  logic              key_up,
   input  logic [2:0]        mouse_btn,
   input  logic [3:0]        mouse_step,
   output logic              key_push,
   output evq_word_t         key_word,
   output logic              mouse_push,
   output evq_word_t         mouse_word
);
   logic [2:0] btn_q;

   always_ff @(posedge clk) begin
      if (rst) btn_q <= '0;
      else     btn_q <= mouse_btn;
   end

   always_comb begin
      key_push      = key_stb;
      key_word.step = 4'b0000;
      key_word.btn  = mouse_btn;
      key_word.code = key_code;
      key_word.rel  = key_up;
      key_word.kbd  = 1'b1;

      mouse_push      = (|mouse_step) || (mouse_btn != btn_q);
      mouse_word.step = mouse_step;
      mouse_word.btn  = mouse_btn;
      mouse_word.code = '0;
      mouse_word.rel  = 1'b0;
      mouse_word.kbd  = 1'b0;
   end
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push_a,
   input  logic [W-1:0] data_a,
   input  logic         push_b,
   input  logic [W-1:0] data_b,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         not_empty,
   output logic         drop
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IW:0] DEPTH_V = (IW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("evq_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  slot [DEPTH];
   logic [IW-1:0] wr_ix, rd_ix, ix_b;
   logic [IW:0]   count, free;
   logic          acc_a, acc_b;

   always_comb begin
      free  = DEPTH_V - count;
      acc_a = push_a && (free != '0);
      acc_b = push_b && (free > (IW+1)'(acc_a));
      ix_b  = wr_ix + IW'(acc_a);
      drop  = (push_a && !acc_a) || (push_b && !acc_b);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (acc_a && wr_ix == IW'(i))     slot[i] <= data_a;
         else if (acc_b && ix_b == IW'(i)) slot[i] <= data_b;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ix <= '0;
         rd_ix <= '0;
         count <= '0;
      end else begin
         wr_ix <= wr_ix + IW'(acc_a) + IW'(acc_b);
         if (pop) rd_ix <= rd_ix + IW'(1);
         count <= count + (IW+1)'(acc_a) + (IW+1)'(acc_b) - (IW+1)'(pop);
      end
   end

   assign head      = slot[rd_ix];
   assign not_empty = (count != '0);

   p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
      count <= DEPTH_V) else $error("queue count above depth");
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
      pop |-> not_empty) else $error("pop from empty queue");
endmodule

// File: rtl/evq_writer.sv
module evq_writer
   import evq_pkg::*;
#(
   parameter int AW       = 16,
   parameter int NIRQ     = 4,
   parameter int RST_ADDR = 'h100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] fifo_head,
   input  logic              fifo_ne,
   output logic              fifo_pop,
   input  logic [AW-1:0]     ring_base,
   input  logic [AW-1:0]     ring_end,
   input  logic [AW-1:0]     out_ptr,
   input  logic [NIRQ-1:0]   sync_mask,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [AW-1:0]     in_ptr,
   output logic [NIRQ-1:0]   irq,
   output logic              ring_drop
);
   localparam int CW = $clog2(ENTRY_WORDS);
   localparam logic [AW-1:0] STRIDE = AW'(ENTRY_WORDS);
   localparam logic [CW-1:0] LAST   = CW'(ENTRY_WORDS - 1);

   typedef enum logic {W_IDLE, W_BUSY} wr_state_t;

   wr_state_t         state;
   logic [CW-1:0]     cnt;
   logic [WORD_W-1:0] word_q;
   logic [AW-1:0]     next_in;
   logic              ring_full;

   always_comb begin
      next_in   = (in_ptr + STRIDE == ring_end) ? ring_base : in_ptr + STRIDE;
      ring_full = (next_in == out_ptr);
      fifo_pop  = (state == W_IDLE) && fifo_ne;
      ring_drop = fifo_pop && ring_full;
      mem_we    = (state == W_BUSY);
      mem_addr  = in_ptr + AW'(cnt);
      mem_wdata = (cnt == '0) ? word_q : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= W_IDLE;
         cnt    <= '0;
         word_q <= '0;
         in_ptr <= AW'(RST_ADDR);
         irq    <= '0;
      end else begin
         irq <= '0;
         case (state)
            W_IDLE: if (fifo_ne && !ring_full) begin
               word_q <= fifo_head;
               cnt    <= '0;
               state  <= W_BUSY;
            end
            W_BUSY: if (cnt == LAST) begin
               in_ptr <= next_in;
               irq    <= sync_mask;
               state  <= W_IDLE;
            end else begin
               cnt <= cnt + CW'(1);
            end
            default: state <= W_IDLE;
         endcase
      end
   end

   p_addr_in_ring_r1: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (mem_addr >= ring_base && mem_addr < ring_end))
      else $error("write outside the ring");
   p_irq_after_last_word_r5: assert property (@(posedge clk) disable iff (rst)
      (|irq) |-> ($past(mem_we) && $past(mem_addr[CW-1:0]) == LAST))
      else $error("interrupt without a completed record");
   p_in_step_r6: assert property (@(posedge clk) disable iff (rst)
      (in_ptr != $past(in_ptr)) |-> (in_ptr == $past(in_ptr) + STRIDE || in_ptr == ring_base))
      else $error("in pointer moved by an illegal amount");
   p_no_write_when_full_r7: assert property (@(posedge clk) disable iff (rst)
      ring_drop |=> !mem_we) else $error("write after a refused record");
endmodule

// File: rtl/evq_ring_writer.sv
module evq_ring_writer
   import evq_pkg::*;
#(
   parameter int AW              = 16,
   parameter int FIFO_DEPTH      = 4,
   parameter int NIRQ            = 4,
   parameter int RING_RESET_ADDR = 'h100
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              key_stb,
   input  logic [6:0]        key_code,
   input  logic              key_up,
   input  logic [2:0]        mouse_btn,
   input  logic [3:0]        mouse_step,
   input  logic [AW-1:0]     ring_base,
   input  logic [AW-1:0]     ring_end,
   input  logic              out_wr,
   input  logic [AW-1:0]     out_wdata,
   input  logic [NIRQ-1:0]   sync_mask,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [15:0]       mem_wdata,
   output logic [AW-1:0]     in_ptr,
   output logic [AW-1:0]     out_ptr,
   output logic [NIRQ-1:0]   irq,
   output logic              overflow
);
   if (AW < 8) begin : g_bad_aw
      $error("evq_ring_writer: AW must be at least 8");
   end
   if (RING_RESET_ADDR % ENTRY_WORDS != 0) begin : g_bad_rst
      $error("evq_ring_writer: reset address must be record aligned");
   end
   if (NIRQ < 1) begin : g_bad_nirq
      $error("evq_ring_writer: NIRQ must be at least 1");
   end

   logic              key_push, mouse_push, fifo_ne, fifo_pop, fifo_drop, ring_drop;
   evq_word_t         key_word, mouse_word;
   logic [WORD_W-1:0] fifo_head;

   evq_encoder u_enc (
      .clk        (clk),
      .rst        (rst),
      .key_stb    (key_stb),
      .key_code   (key_code),
      .key_up     (key_up),
      .mouse_btn  (mouse_btn),
      .mouse_step (mouse_step),
      .key_push   (key_push),
      .key_word   (key_word),
      .mouse_push (mouse_push),
      .mouse_word (mouse_word)
   );

   evq_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push_a    (key_push),
      .data_a    (key_word),
      .push_b    (mouse_push),
      .data_b    (mouse_word),
      .pop       (fifo_pop),
      .head      (fifo_head),
      .not_empty (fifo_ne),
      .drop      (fifo_drop)
   );

   evq_writer #(.AW(AW), .NIRQ(NIRQ), .RST_ADDR(RING_RESET_ADDR)) u_wr (
      .clk       (clk),
      .rst       (rst),
      .fifo_head (fifo_head),
      .fifo_ne   (fifo_ne),
      .fifo_pop  (fifo_pop),
      .ring_base (ring_base),
      .ring_end  (ring_end),
      .out_ptr   (out_ptr),
      .sync_mask (sync_mask),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .in_ptr    (in_ptr),
      .irq       (irq),
      .ring_drop (ring_drop)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_ptr  <= AW'(RING_RESET_ADDR);
         overflow <= 1'b0;
      end else begin
         if (out_wr) out_ptr <= out_wdata;
         if (fifo_drop || ring_drop) overflow <= 1'b1;
      end
   end

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow) else $error("overflow flag cleared");
   p_out_load_r9: assert property (@(posedge clk) disable iff (rst)
      out_wr |=> (out_ptr == $past(out_wdata))) else $error("out pointer load lost");
endmodule

// File: tb/evq_ring_writer_test.sv
`timescale 1ns/1ps
module evq_ring_writer_test;
   localparam int AW    = 16;
   localparam int DEPTH = 4;
   localparam int NIRQ  = 4;
   localparam int RADDR = 'h100;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            key_stb = 1'b0;
   logic [6:0]      key_code = '0;
   logic            key_up = 1'b0;
   logic [2:0]      mouse_btn = '0;
   logic [3:0]      mouse_step = '0;
   logic [AW-1:0]   ring_base = 16'h0100;
   logic [AW-1:0]   ring_end  = 16'h0114;
   logic            out_wr = 1'b0;
   logic [AW-1:0]   out_wdata = '0;
   logic [NIRQ-1:0] sync_mask = 4'b1010;
   logic            mem_we;
   logic [AW-1:0]   mem_addr, in_ptr, out_ptr;
   logic [15:0]     mem_wdata;
   logic [NIRQ-1:0] irq;
   logic            overflow;

   evq_ring_writer #(.AW(AW), .FIFO_DEPTH(DEPTH), .NIRQ(NIRQ), .RING_RESET_ADDR(RADDR)) uut (
      .clk(clk), .rst(rst), .key_stb(key_stb), .key_code(key_code), .key_up(key_up),
      .mouse_btn(mouse_btn), .mouse_step(mouse_step), .ring_base(ring_base),
      .ring_end(ring_end), .out_wr(out_wr), .out_wdata(out_wdata), .sync_mask(sync_mask),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .in_ptr(in_ptr),
      .out_ptr(out_ptr), .irq(irq), .overflow(overflow)
   );

   always #2.5 clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mkword(input logic [3:0] st, input logic [2:0] bt,
                                          input logic [6:0] kc, input logic rl, input logic kb);
      return {st, bt, kc, rl, kb};
   endfunction

   // behavioural reference model
   int          q[$];
   int          m_in, m_out, m_busy, m_cnt, m_word, m_irq, m_ovf, m_prev_btn, m_free, m_nx;
   logic [15:0] img [0:255];

   always @(posedge clk) begin
      if (mem_we) img[mem_addr[7:0]] = mem_wdata;
      if (rst) begin
         q.delete();
         m_in = RADDR; m_out = RADDR; m_busy = 0; m_cnt = 0; m_word = 0;
         m_irq = 0; m_ovf = 0; m_prev_btn = 0;
      end else begin
         m_free = DEPTH - q.size();
         m_irq  = 0;
         m_nx   = (m_in + 4 == int'(ring_end)) ? int'(ring_base) : m_in + 4;
         if (m_busy == 0) begin
            if (q.size() > 0) begin
               if (m_nx == m_out) begin
                  void'(q.pop_front());
                  m_ovf = 1;
               end else begin
                  m_word = q.pop_front();
                  m_busy = 1;
                  m_cnt  = 0;
               end
            end
         end else if (m_cnt == 3) begin
            m_in   = m_nx;
            m_irq  = int'(sync_mask);
            m_busy = 0;
         end else begin
            m_cnt++;
         end
         if (out_wr) m_out = int'(out_wdata);
         if (key_stb) begin
            if (m_free > 0) begin
               q.push_back(int'(mkword(4'b0, mouse_btn, key_code, key_up, 1'b1)));
               m_free--;
            end else m_ovf = 1;
         end
         if (mouse_step != 0 || int'(mouse_btn) != m_prev_btn) begin
            if (m_free > 0) q.push_back(int'(mkword(mouse_step, mouse_btn, 7'd0, 1'b0, 1'b0)));
            else m_ovf = 1;
         end
         m_prev_btn = int'(mouse_btn);
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (!rst) begin
         check(int'(mem_we) == m_busy, "R1 write enable", int'(mem_we), m_busy);
         if (mem_we && m_busy != 0) begin
            check(int'(mem_addr) == m_in + m_cnt, "R1 address", int'(mem_addr), m_in + m_cnt);
            if (m_cnt == 0)
               check(int'(mem_wdata) == m_word, "R2 word0", int'(mem_wdata), m_word);
            else
               check(mem_wdata == 16'h0, "R4 padding", int'(mem_wdata), 0);
         end
         check(int'(irq) == m_irq, "R5 irq", int'(irq), m_irq);
         check(int'(in_ptr) == m_in, "R5 in_ptr", int'(in_ptr), m_in);
         check(int'(overflow) == m_ovf, "R7 overflow", int'(overflow), m_ovf);
         check(int'(out_ptr) == m_out, "R9 out_ptr", int'(out_ptr), m_out);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic ks, input logic [6:0] kc, input logic ku,
                        input logic [3:0] st, input logic [2:0] bt);
      @(negedge clk);
      key_stb = ks; key_code = kc; key_up = ku; mouse_step = st; mouse_btn = bt;
      @(negedge clk);
      key_stb = 1'b0; mouse_step = 4'b0;
   endtask

   task automatic load_out(input logic [AW-1:0] v);
      @(negedge clk); out_wr = 1'b1; out_wdata = v;
      @(negedge clk); out_wr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; mouse_btn = '0;
      idle(2);
      rst = 1'b0;
      @(negedge clk);
      check(in_ptr == 16'h0100 && out_ptr == 16'h0100, "R10 pointers", int'(in_ptr), 'h100);
      check(irq == '0 && !overflow && !mem_we, "R10 outputs",
            int'({irq, overflow, mem_we}), 0);
   endtask

   initial begin
      idle(3);
      rst = 1'b0;
      @(negedge clk);
      check(in_ptr == 16'h0100 && out_ptr == 16'h0100, "R10 pointers", int'(in_ptr), 'h100);
      check(irq == '0 && !overflow && !mem_we, "R10 outputs", int'({irq, overflow, mem_we}), 0);

      // key press
      pulse(1'b1, 7'h41, 1'b0, 4'b0, 3'b000);
      idle(8);
      check(img[8'h00] == mkword(4'b0, 3'b000, 7'h41, 1'b0, 1'b1), "R3 key record",
            int'(img[8'h00]), int'(mkword(4'b0, 3'b000, 7'h41, 1'b0, 1'b1)));
      check(img[8'h01] == 0 && img[8'h02] == 0 && img[8'h03] == 0, "R4 padding words",
            int'(img[8'h03]), 0);
      check(in_ptr == 16'h0104, "R5 advance", int'(in_ptr), 'h104);

      load_out(16'h0104);
      check(out_ptr == 16'h0104, "R9 load", int'(out_ptr), 'h104);

      // step with button press in the same cycle
      pulse(1'b0, 7'h0, 1'b0, 4'b1000, 3'b100);
      idle(8);
      check(img[8'h04] == mkword(4'b1000, 3'b100, 7'h0, 1'b0, 1'b0), "R4 mouse record",
            int'(img[8'h04]), int'(mkword(4'b1000, 3'b100, 7'h0, 1'b0, 1'b0)));

      // button release alone
      @(negedge clk); mouse_btn = 3'b000;
      idle(9);
      check(img[8'h08] == 16'h0000 && in_ptr == 16'h010C, "R4 button change",
            int'(in_ptr), 'h10C);

      // key release and diagonal step in one cycle
      pulse(1'b1, 7'h12, 1'b1, 4'b1010, 3'b001);
      idle(14);
      check(img[8'h0C] == mkword(4'b0, 3'b001, 7'h12, 1'b1, 1'b1), "R8 key first",
            int'(img[8'h0C]), int'(mkword(4'b0, 3'b001, 7'h12, 1'b1, 1'b1)));
      check(img[8'h10] == mkword(4'b1010, 3'b001, 7'h0, 1'b0, 1'b0), "R8 mouse second",
            int'(img[8'h10]), int'(mkword(4'b1010, 3'b001, 7'h0, 1'b0, 1'b0)));
      check(in_ptr == 16'h0100, "R6 wrap", int'(in_ptr), 'h100);

      // ring full: next in equals out
      pulse(1'b1, 7'h33, 1'b0, 4'b0, 3'b001);
      idle(6);
      check(overflow == 1'b1, "R7 full drop flag", int'(overflow), 1);
      check(in_ptr == 16'h0100 && img[8'h00] == mkword(4'b0, 3'b000, 7'h41, 1'b0, 1'b1),
            "R7 no write", int'(img[8'h00]), int'(mkword(4'b0, 3'b000, 7'h41, 1'b0, 1'b1)));

      // free space, write at base after the wrap
      load_out(16'h010C);
      sync_mask = 4'b0110;
      pulse(1'b1, 7'h55, 1'b0, 4'b0, 3'b001);
      idle(8);
      check(img[8'h00] == mkword(4'b0, 3'b001, 7'h55, 1'b0, 1'b1) && in_ptr == 16'h0104,
            "R6 write at base", int'(img[8'h00]), int'(mkword(4'b0, 3'b001, 7'h55, 1'b0, 1'b1)));
      check(overflow == 1'b1, "R7 sticky", int'(overflow), 1);

      // queue exhaustion
      do_reset();
      sync_mask = 4'b0101;
      @(negedge clk); key_stb = 1; key_code = 7'h01; mouse_step = 4'b0001;
      @(negedge clk); key_code = 7'h02; mouse_step = 4'b0100;
      @(negedge clk); key_code = 7'h03; mouse_step = 4'b0011;
      @(negedge clk); key_stb = 0; mouse_step = 4'b0;
      check(overflow == 1'b1, "R8 queue full", int'(overflow), 1);
      idle(40);
      load_out(16'h0110);
      pulse(1'b0, 7'h0, 1'b0, 4'b0100, 3'b010);
      idle(10);
      pulse(1'b1, 7'h7F, 1'b1, 4'b0, 3'b010);
      idle(10);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule